// File: doc/BRIEF.md
# Auto-Reload Timer With PWM

This block is an 8-bit up-counter that runs from one of several prescaled tick strobes or from a slow external clock input. In its plain timing use it counts up to all-ones, wraps and raises a sticky interrupt flag. An optional reload value replaces the wrap to zero. An optional square-wave output flips on every wrap, which suits a buzzer.

A PWM mode reuses the same counter. The reload register then holds the duty value. The two control bits that select reload and square wave in plain mode instead choose the PWM period: 256, 64, 32 or 16 counts. The duty value is held in two stages, a pending copy that the bus writes and an active copy used for the compare. The pending copy moves to the active copy only at the start of a period, so a duty change never cuts a pulse short.

Software sets a mode byte and can preset the count while the timer is stopped. It writes the reload/duty value at any time and clears the interrupt flag with a one-cycle strobe. Pin multiplexing and the processor bus sit outside the block.

Top module: `timer_pwm8`

## Requirements
- R1: Reset clears the count, the interrupt flag, the square-wave output and the PWM output. The mode byte is decoded as: bit 7 run, bits 6:4 tick select, bit 3 external clock select, bit 2 reload/period-high, bit 1 square-wave/period-low, bit 0 PWM mode.
- R2: With PWM off, a count step at 0xFF wraps the count and sets the interrupt flag. The flag stays set until the clear strobe. A wrap in the same cycle as the clear strobe leaves the flag set.
- R3: With PWM off and bit 2 set, a wrap loads the count from the most recently written reload value instead of 0x00.
- R4: With PWM off and bit 1 set, the square-wave output inverts on every wrap. In PWM mode it does not change.
- R5: In PWM mode the count runs from 0 to P-1 and then returns to 0. P is set by {bit2,bit1}: 00 gives 256, 01 gives 64, 10 gives 32, 11 gives 16.
- R6: In PWM mode the output is high while the count is below the active duty value and low otherwise. A duty of 0 keeps it low for the whole period.
- R7: A duty write while the timer runs goes only to the pending copy. It becomes active when the count returns to 0. A write while stopped takes effect at once.
- R8: In PWM mode the interrupt flag is set once per period, on the step that returns the count to 0.
- R9: A count write while stopped presets the count on the next cycle. A count write while running is ignored.
- R10: While stopped, the count (apart from a preset), the square-wave output and the PWM output hold their values.
- R11: A step comes from the tick strobe chosen by bits 6:4. With bit 3 set, a step comes instead from each rising edge of the external clock after a two-stage synchronizer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 8 | Mode byte |
| rate_tick_i | input | 8 | Prescaled tick strobes, one per rate |
| ext_clk_i | input | 1 | Asynchronous external count clock |
| cnt_wr_i | input | 1 | Count preset strobe |
| cnt_wdata_i | input | 8 | Count preset value |
| rld_wr_i | input | 1 | Reload/duty write strobe |
| rld_wdata_i | input | 8 | Reload/duty value |
| irq_clr_i | input | 1 | Interrupt flag clear strobe |
| cnt_o | output | 8 | Current count |
| irq_o | output | 1 | Interrupt request flag |
| tog_o | output | 1 | Square-wave output |
| pwm_o | output | 1 | PWM output |

## Verification
Two pairs of events can fall in the same cycle. The first is a wrap and the software clear of the interrupt flag. The bench presets the count to 0xFE, lets it step to 0xFF, and holds the clear strobe across the wrapping edge; the flag must read set afterwards and clear one cycle later. The second is a duty write and a running PWM period. The bench writes a new duty in the middle of a 16-count period and checks every later cycle: the old duty must govern the output until the count returns to 0, and the new duty from then on.

// File: rtl/timer_pwm8_pkg.sv
package timer_pwm8_pkg;
  localparam int RATE_W = 3;
  localparam int NRATE  = 1 << RATE_W;
  localparam int MODE_W = 8;

  typedef struct packed {
    logic              run;
    logic [RATE_W-1:0] rate;
    logic              ext;
    logic              aload;
    logic              sqw;
    logic              pwm;
  } mode_t;
endpackage

// File: rtl/tc_step_sel.sv
module tc_step_sel
  import timer_pwm8_pkg::*;
#(
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NRATE-1:0]  rate_tick_i,
  input  logic [RATE_W-1:0] rate_sel_i,
  input  logic              ext_sel_i,
  input  logic              ext_clk_i,
  output logic              step_o
);
  logic [SYNC_N-1:0] sync_q;
  logic              prev_q;

  generate
    for (genvar s = 0; s < SYNC_N; s++) begin : g_sync
      always_ff @(posedge clk) begin
        if (rst) sync_q[s] <= 1'b0;
        else if (s == 0) sync_q[s] <= ext_clk_i;
        else sync_q[s] <= sync_q[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= sync_q[SYNC_N-1];
  end

  always_comb begin
    if (ext_sel_i) step_o = sync_q[SYNC_N-1] & ~prev_q;
    else           step_o = rate_tick_i[rate_sel_i];
  end
endmodule

// File: rtl/tc_count_core.sv
module tc_count_core #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en_i,
  input  logic         step_i,
  input  logic         pwm_i,
  input  logic         aload_i,
  input  logic         sqw_i,
  input  logic [1:0]   per_sel_i,
  input  logic         cnt_wr_i,
  input  logic [W-1:0] cnt_wdata_i,
  input  logic [W-1:0] rld_i,
  input  logic         irq_clr_i,
  output logic [W-1:0] cnt_o,
  output logic [W-1:0] cnt_nxt_o,
  output logic         bnd_o,
  output logic         tog_o,
  output logic         irq_o
);
  localparam logic [W-1:0] ALL1 = '1;

  logic [W-1:0] cnt_q;
  logic [W-1:0] mask;
  logic         adv;
  logic         at_end;

  always_comb begin
    case (per_sel_i)
      2'b00:   mask = ALL1;
      2'b01:   mask = ALL1 >> 2;
      2'b10:   mask = ALL1 >> 3;
      default: mask = ALL1 >> 4;
    endcase
    adv    = en_i & step_i;
    at_end = pwm_i ? ((cnt_q & mask) == mask) : (cnt_q == ALL1);
    bnd_o  = adv & at_end;

    cnt_nxt_o = cnt_q;
    if (!en_i && cnt_wr_i)        cnt_nxt_o = cnt_wdata_i;
    else if (bnd_o)               cnt_nxt_o = (!pwm_i && aload_i) ? rld_i : '0;
    else if (adv)                 cnt_nxt_o = cnt_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      irq_o <= 1'b0;
      tog_o <= 1'b0;
    end else begin
      cnt_q <= cnt_nxt_o;
      if (bnd_o)          irq_o <= 1'b1;
      else if (irq_clr_i) irq_o <= 1'b0;
      if (bnd_o && !pwm_i && sqw_i) tog_o <= ~tog_o;
    end
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/tc_pwm_unit.sv
module tc_pwm_unit #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en_i,
  input  logic         pwm_i,
  input  logic         bnd_i,
  input  logic         rld_wr_i,
  input  logic [W-1:0] rld_wdata_i,
  input  logic [W-1:0] cnt_nxt_i,
  output logic [W-1:0] pend_o,
  output logic         pwm_o
);
  logic [W-1:0] pend_q;
  logic [W-1:0] act_q;
  logic [W-1:0] act_nxt;

  always_comb begin
    act_nxt = act_q;
    if (!en_i && rld_wr_i) act_nxt = rld_wdata_i;
    else if (bnd_i)        act_nxt = pend_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
      act_q  <= '0;
      pwm_o  <= 1'b0;
    end else begin
      if (rld_wr_i) pend_q <= rld_wdata_i;
      act_q <= act_nxt;
      if (en_i) pwm_o <= pwm_i && (cnt_nxt_i < act_nxt);
    end
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/timer_pwm8.sv
module timer_pwm8
  import timer_pwm8_pkg::*;
#(
  parameter int W      = 8,
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [MODE_W-1:0] mode_i,
  input  logic [NRATE-1:0]  rate_tick_i,
  input  logic              ext_clk_i,
  input  logic              cnt_wr_i,
  input  logic [W-1:0]      cnt_wdata_i,
  input  logic              rld_wr_i,
  input  logic [W-1:0]      rld_wdata_i,
  input  logic              irq_clr_i,
  output logic [W-1:0]      cnt_o,
  output logic              irq_o,
  output logic              tog_o,
  output logic              pwm_o
);
  mode_t        m;
  logic         step;
  logic         bnd;
  logic [W-1:0] cnt_nxt;
  logic [W-1:0] pend;

  assign m = mode_t'(mode_i);

  tc_step_sel #(.SYNC_N(SYNC_N)) u_step (
    .clk(clk), .rst(rst), .rate_tick_i(rate_tick_i), .rate_sel_i(m.rate),
    .ext_sel_i(m.ext), .ext_clk_i(ext_clk_i), .step_o(step)
  );

  tc_count_core #(.W(W)) u_core (
    .clk(clk), .rst(rst), .en_i(m.run), .step_i(step), .pwm_i(m.pwm),
    .aload_i(m.aload), .sqw_i(m.sqw), .per_sel_i({m.aload, m.sqw}),
    .cnt_wr_i(cnt_wr_i), .cnt_wdata_i(cnt_wdata_i), .rld_i(pend),
    .irq_clr_i(irq_clr_i), .cnt_o(cnt_o), .cnt_nxt_o(cnt_nxt), .bnd_o(bnd),
    .tog_o(tog_o), .irq_o(irq_o)
  );

  tc_pwm_unit #(.W(W)) u_pwm (
    .clk(clk), .rst(rst), .en_i(m.run), .pwm_i(m.pwm), .bnd_i(bnd),
    .rld_wr_i(rld_wr_i), .rld_wdata_i(rld_wdata_i), .cnt_nxt_i(cnt_nxt),
    .pend_o(pend), .pwm_o(pwm_o)
  );
endmodule

// File: rtl/timer_pwm8_chk.sv
module timer_pwm8_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         mode_run,
  input logic         mode_pwm,
  input logic         cnt_wr_i,
  input logic         irq_clr_i,
  input logic [W-1:0] cnt_o,
  input logic         irq_o,
  input logic         tog_o,
  input logic         pwm_o
);
  // R2
  irq_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    irq_o && !irq_clr_i |=> irq_o);

  // R2
  irq_src_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_o) |-> ($past(cnt_o) == '1) || $past(mode_pwm));

  // R8
  pwm_irq_zero_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_o) && $past(mode_pwm) |-> cnt_o == '0);

  // R4
  sqw_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    mode_run && mode_pwm |=> $stable(tog_o));

  // R10
  hold_cnt_chk: assert property (@(posedge clk) disable iff (rst)
    !mode_run && !cnt_wr_i |=> $stable(cnt_o));

  // R10
  hold_out_chk: assert property (@(posedge clk) disable iff (rst)
    !mode_run |=> $stable(tog_o) && $stable(pwm_o));
endmodule

bind timer_pwm8 timer_pwm8_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .mode_run(mode_i[7]), .mode_pwm(mode_i[0]),
  .cnt_wr_i(cnt_wr_i), .irq_clr_i(irq_clr_i), .cnt_o(cnt_o),
  .irq_o(irq_o), .tog_o(tog_o), .pwm_o(pwm_o)
);

// File: tb/tb_timer_pwm8.sv
`timescale 1ns/1ps
module tb_timer_pwm8;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] mode = 8'h00;
  logic [7:0] ticks = 8'hFF;
  logic       ext = 1'b0;
  logic       cnt_wr = 1'b0;
  logic [7:0] cnt_wd = 8'h00;
  logic       rld_wr = 1'b0;
  logic [7:0] rld_wd = 8'h00;
  logic       irq_clr = 1'b0;
  logic [7:0] cnt;
  logic       irq, tog, pwm;

  int n_cmp = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  timer_pwm8 dut (
    .clk(clk), .rst(rst), .mode_i(mode), .rate_tick_i(ticks), .ext_clk_i(ext),
    .cnt_wr_i(cnt_wr), .cnt_wdata_i(cnt_wd), .rld_wr_i(rld_wr),
    .rld_wdata_i(rld_wd), .irq_clr_i(irq_clr), .cnt_o(cnt), .irq_o(irq),
    .tog_o(tog), .pwm_o(pwm)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  // stop, preset count and duty/reload, clear the flag
  task automatic preset(input logic [7:0] c, input logic [7:0] d);
    mode = {1'b0, mode[6:0]};
    cnt_wr = 1'b1; cnt_wd = c;
    rld_wr = 1'b1; rld_wd = d;
    irq_clr = 1'b1;
    cyc(1);
    cnt_wr = 1'b0; rld_wr = 1'b0; irq_clr = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int t0;
    logic [7:0] c_s;
    logic t_s, p_s;
    cyc(3);
    rst = 1'b0;
    cyc(1);
    // R1 reset state
    chk("R1 cnt", cnt, 0); chk("R1 irq", irq, 0);
    chk("R1 tog", tog, 0); chk("R1 pwm", pwm, 0);

    // R9 preset while stopped
    preset(8'hF0, 8'h00);
    chk("R9 preset", cnt, 8'hF0);

    // R2 plain wrap, no reload
    mode = 8'h80;
    cyc(15);
    chk("R2 cnt before wrap", cnt, 8'hFF); chk("R2 irq before wrap", irq, 0);
    cyc(1);
    chk("R2 wrap to zero", cnt, 8'h00); chk("R2 irq set", irq, 1);
    cyc(2);
    chk("R2 irq sticky", irq, 1); chk("R2 count on", cnt, 8'h02);
    // R9 write while running is ignored
    cnt_wr = 1'b1; cnt_wd = 8'h55;
    cyc(1);
    cnt_wr = 1'b0;
    chk("R9 ignored when running", cnt, 8'h03);

    // R3 auto-reload
    preset(8'hFE, 8'hFA);
    mode = 8'h84;
    cyc(1);
    chk("R3 cnt", cnt, 8'hFF);
    cyc(1);
    chk("R3 reload", cnt, 8'hFA); chk("R3 irq", irq, 1);
    cyc(6);
    chk("R3 second reload", cnt, 8'hFA);

    // R4 square wave: period of 4 steps
    preset(8'hFC, 8'hFC);
    t0 = tog;
    mode = 8'h86;
    for (int n = 1; n <= 16; n++) begin
      cyc(1);
      chk("R4 cnt", cnt, 8'hFC + (n % 4));
      chk("R4 tog", tog, t0 ^ ((n / 4) & 1));
    end

    // R2 wrap coincides with clear: set wins
    preset(8'hFE, 8'h00);
    mode = 8'h80;
    cyc(1);
    chk("R2 pre-wrap irq", irq, 0);
    irq_clr = 1'b1;
    cyc(1);
    chk("R2 set beats clear", irq, 1);
    cyc(1);
    irq_clr = 1'b0;
    chk("R2 clear", irq, 0);

    // R5 R6 R8 PWM sweep over periods and duties
    for (int ps = 0; ps < 4; ps++) begin
      int p;
      p = (ps == 0) ? 256 : (ps == 1) ? 64 : (ps == 2) ? 32 : 16;
      for (int di = 0; di < 4; di++) begin
        int d;
        d = (di == 0) ? 0 : (di == 1) ? 3 : (di == 2) ? p / 2 : 255;
        preset(8'h00, d[7:0]);
        mode = 8'h81 | (ps[7:0] << 1);
        for (int n = 1; n <= p + 4; n++) begin
          cyc(1);
          chk("R5 pwm count", cnt, n % p);
          chk("R6 pwm level", pwm, ((n % p) < d) ? 1 : 0);
          chk("R8 pwm irq", irq, (n >= p) ? 1 : 0);
        end
      end
    end

    // R7 duty change mid-period, period 16
    preset(8'h00, 8'h04);
    mode = 8'h87;
    cyc(5);
    rld_wr = 1'b1; rld_wd = 8'h0A;
    cyc(1);
    rld_wr = 1'b0;
    chk("R7 old duty", pwm, 0);
    for (int n = 7; n <= 36; n++) begin
      cyc(1);
      chk("R7 buffered duty", pwm, ((n % 16) < ((n < 16) ? 4 : 10)) ? 1 : 0);
    end

    // R10 freeze while stopped
    c_s = cnt; t_s = tog; p_s = pwm;
    mode = 8'h07;
    cyc(5);
    chk("R10 cnt held", cnt, c_s);
    chk("R10 tog held", tog, t_s);
    chk("R10 pwm held", pwm, p_s);

    // R11 tick select: only bit 5 counts
    preset(8'h20, 8'h00);
    mode = 8'hD0;
    ticks = 8'hDF;
    cyc(3);
    chk("R11 other ticks ignored", cnt, 8'h20);
    ticks = 8'h20;
    cyc(2);
    chk("R11 selected tick", cnt, 8'h22);
    ticks = 8'hFF;

    // R11 external clock rising edges
    preset(8'h10, 8'h00);
    mode = 8'h88;
    ext = 1'b1;
    cyc(6);
    chk("R11 ext one edge", cnt, 8'h11);
    cyc(3);
    chk("R11 ext level no step", cnt, 8'h11);
    for (int k = 0; k < 3; k++) begin
      ext = 1'b0; cyc(4);
      ext = 1'b1; cyc(4);
    end
    chk("R11 ext three edges", cnt, 8'h14);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule